// File: doc/BRIEF.md
# SPI Write Collision Guard

This block sits beside a single-buffered SPI shifter. It tracks whether a serial transfer is under way and decides whether each bus write to the data register may reach the shifter. The transmit path has no holding register, so a write that arrives mid-transfer would corrupt the bits being shifted. Such a write is refused: the shift-register load enable stays low, the data is lost, the running transfer goes on unchanged, and a sticky collision flag is raised.

When a transfer counts as in progress depends on the role and the clock phase. A master is busy from its accepted data write until the shifter reports completion. A slave with clock phase 0 is busy for as long as slave-select is held low. A slave with clock phase 1 is busy from the first serial-clock edge it sees while selected until completion. The collision flag and the transfer-complete flag are cleared only by an ordered sequence. Software first reads status while a flag is set. It then reads the data register, or writes it once the transfer is complete. The completion flag can also raise an interrupt request, but a collision never does.

Top module: `spi_wcol_guard`

## Requirements
- R1: While rst_n is low at a clock edge, wcol_flag, done_flag, the clearing arm and the transfer-in-progress state all return to 0. With no write present, load_en and spi_irq are then 0.
- R2: In master role (is_master=1), a data write (bus_wr=1, bus_sel_data=1) with no transfer running drives load_en=1 in that same cycle. It starts a transfer that lasts until xfer_done is seen.
- R3: A data write while a transfer is running keeps load_en at 0 and sets wcol_flag at the next clock. The running transfer is undisturbed and still finishes on its xfer_done.
- R4: In slave role with cpha=0, a transfer counts as running exactly while ss_n is low. A data write with ss_n high is loaded, and one with ss_n low collides.
- R5: In slave role with cpha=1, a transfer starts when sck changes level between two clock samples while ss_n is low. It ends when xfer_done is seen, and xfer_done wins if both occur in the same cycle.
- R6: An xfer_done pulse sets done_flag at the next clock.
- R7: A status read (bus_rd=1, bus_sel_data=0) while either flag is set arms the clearing sequence. A later data read (bus_rd=1, bus_sel_data=1) then clears both flags at the next clock, whether or not a transfer is still running.
- R8: When the sequence is armed and done_flag is set, an accepted data write clears both flags at the next clock and also drives load_en=1.
- R9: A data write during a transfer after arming is a further collision and drops the arm. A following data read leaves both flags set.
- R10: A status read while both flags are clear does not arm. A data read without a prior arming status read changes neither flag.
- R11: spi_irq equals irq_en AND done_flag. A collision alone never raises spi_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_sel_data | input | 1 | 1 selects the data register, 0 selects status |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| cpha | input | 1 | Clock phase setting used in slave role |
| ss_n | input | 1 | Slave-select, active low, synchronous to clk |
| sck | input | 1 | Serial clock level, sampled on clk |
| xfer_done | input | 1 | One-cycle completion pulse from the shifter |
| irq_en | input | 1 | Interrupt enable for the completion flag |
| load_en | output | 1 | Load strobe that moves write data into the shifter |
| wcol_flag | output | 1 | Sticky write-collision flag |
| done_flag | output | 1 | Sticky transfer-complete flag |
| spi_irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is an armed clearing sequence that is broken by a fresh collision. It needs a running transfer, a flag already set and a status read, all before the next data write. The stimulus table gets there by starting a master transfer and colliding once. It then reads status, collides again while the same transfer is still open, and shows that a data read no longer clears anything. A reset between an arming read and a data read is added as a directed case, so that a stale arm cannot survive reset.

// File: rtl/spi_wcol_pkg.sv
// Package: shared types for the SPI write collision guard.
// Assumes: nothing beyond the three operating roles listed here.
package spi_wcol_pkg;

    // Operating role as seen by the transfer window tracker
    typedef enum logic [1:0] {
        ROLE_MASTER    = 2'd0,
        ROLE_SLAVE_PH0 = 2'd1,
        ROLE_SLAVE_PH1 = 2'd2
    } wcol_role_e;

endpackage

// File: rtl/spi_xfer_window.sv
// Module: spi_xfer_window
// Tracks whether a serial transfer is in progress for the current role.
// Assumes: ss_n and sck are already synchronous to clk; xfer_done is a
// single-cycle pulse; sck idles at SCK_IDLE when reset is released.
module spi_xfer_window
    import spi_wcol_pkg::*;
#(
    parameter logic SCK_IDLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_master,
    input  logic cpha,
    input  logic ss_n,
    input  logic sck,
    input  logic xfer_done,
    input  logic wr_accepted,
    output logic busy
);

    wcol_role_e role;
    logic       sck_q;
    logic       sck_edge;
    logic       run_q;
    logic       run_start;

    // Decode the operating role from the configuration bits
    always_comb begin
        if (is_master)  role = ROLE_MASTER;
        else if (cpha)  role = ROLE_SLAVE_PH1;
        else            role = ROLE_SLAVE_PH0;
    end

    // Sample sck to find level changes
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= SCK_IDLE;
        else        sck_q <= sck;
    end

    assign sck_edge = sck ^ sck_q;

    // Start condition for a transfer held in run_q
    always_comb begin
        unique case (role)
            ROLE_MASTER:    run_start = wr_accepted;
            ROLE_SLAVE_PH1: run_start = sck_edge & ~ss_n;
            default:        run_start = 1'b0;
        endcase
    end

    // Hold the running state until completion; completion wins
    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= 1'b0;
        else if (xfer_done) run_q <= 1'b0;
        else if (run_start) run_q <= 1'b1;
    end

    // Select the in-progress window for the current role
    always_comb begin
        unique case (role)
            ROLE_SLAVE_PH0: busy = ~ss_n;
            default:        busy = run_q;
        endcase
    end

endmodule

// File: rtl/spi_wcol_flags.sv
// Module: spi_wcol_flags
// Holds the collision and completion flags and the two-step clearing arm.
// Assumes: strobes are single-cycle; collide and wr_ok never coincide.
module spi_wcol_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic collide,
    input  logic wr_ok,
    input  logic stat_rd,
    input  logic dat_rd,
    input  logic xfer_done,
    output logic wcol,
    output logic done,
    output logic armed
);

    logic clr;

    // Second step of the clearing sequence
    assign clr = armed & (dat_rd | (wr_ok & done));

    // Arm on a status read that sees a flag; drop it on collision or use
    always_ff @(posedge clk) begin
        if (!rst_n)                      armed <= 1'b0;
        else if (collide)                armed <= 1'b0;
        else if (clr)                    armed <= 1'b0;
        else if (stat_rd & (wcol | done)) armed <= 1'b1;
    end

    // Collision flag: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)       wcol <= 1'b0;
        else if (collide) wcol <= 1'b1;
        else if (clr)     wcol <= 1'b0;
    end

    // Completion flag: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)         done <= 1'b0;
        else if (xfer_done) done <= 1'b1;
        else if (clr)       done <= 1'b0;
    end

endmodule

// File: rtl/spi_wcol_guard.sv
// Module: spi_wcol_guard (top)
// Gates data-register writes into a single-buffered SPI shifter and flags
// writes that arrive while a transfer is in progress.
// Assumes: one bus access per cycle; bus_sel_data=1 selects data register.
module spi_wcol_guard #(
    parameter logic SCK_IDLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rd,
    input  logic bus_wr,
    input  logic bus_sel_data,
    input  logic is_master,
    input  logic cpha,
    input  logic ss_n,
    input  logic sck,
    input  logic xfer_done,
    input  logic irq_en,
    output logic load_en,
    output logic wcol_flag,
    output logic done_flag,
    output logic spi_irq
);

    logic busy;
    logic armed;
    logic dat_wr;
    logic collide;

    // Bus decode: data writes either load or collide
    assign dat_wr  = bus_wr & bus_sel_data;
    assign load_en = dat_wr & ~busy;
    assign collide = dat_wr & busy;

    spi_xfer_window #(
        .SCK_IDLE (SCK_IDLE)
    ) u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .is_master   (is_master),
        .cpha        (cpha),
        .ss_n        (ss_n),
        .sck         (sck),
        .xfer_done   (xfer_done),
        .wr_accepted (load_en),
        .busy        (busy)
    );

    spi_wcol_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .collide   (collide),
        .wr_ok     (load_en),
        .stat_rd   (bus_rd & ~bus_sel_data),
        .dat_rd    (bus_rd & bus_sel_data),
        .xfer_done (xfer_done),
        .wcol      (wcol_flag),
        .done      (done_flag),
        .armed     (armed)
    );

    // Only completion can request an interrupt
    assign spi_irq = irq_en & done_flag;

endmodule

// File: rtl/spi_wcol_guard_chk.sv
// Module: spi_wcol_guard_chk
// Temporal checks on the guard, bound into every spi_wcol_guard instance.
module spi_wcol_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_wr,
    input logic bus_sel_data,
    input logic is_master,
    input logic xfer_done,
    input logic load_en,
    input logic wcol_flag,
    input logic done_flag,
    input logic spi_irq,
    input logic busy,
    input logic armed
);

    AST_COLLIDE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel_data && busy) |=> wcol_flag); // R3

    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> done_flag); // R6

    AST_MASTER_WINDOW_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && load_en && !xfer_done) |=> (busy || !is_master)); // R2

    AST_WCOL_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wcol_flag) |-> $past(armed)); // R7

    AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        spi_irq |-> done_flag); // R11

    AST_WCOL_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wcol_flag) && !done_flag) |-> !spi_irq); // R11

endmodule

bind spi_wcol_guard spi_wcol_guard_chk u_chk (.*);

// File: tb/spi_wcol_guard_bench.sv
// Bench: stimulus table walked step by step, then directed reset cases.
module spi_wcol_guard_bench;

    logic clk = 1'b0;
    logic rst_n;
    logic bus_rd, bus_wr, bus_sel_data, is_master, cpha, ss_n, sck;
    logic xfer_done, irq_en;
    logic load_en, wcol_flag, done_flag, spi_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    spi_wcol_guard u_spi_wcol_guard (.*);

    // Vector: {rd wr dat}{mst cph ssn}{sck xd ie}{ld wc dn irq}
    localparam int NV = 36;
    localparam logic [12:0] VEC [NV] = '{
        13'b000_101_001_0000, // 0  R1 idle master
        13'b011_101_001_1000, // 1  R2 accepted write
        13'b011_101_001_0100, // 2  R3 collision, no irq (R11)
        13'b000_101_011_0111, // 3  R6 completion
        13'b100_101_001_0111, // 4  R7 arm
        13'b101_101_001_0000, // 5  R7 data read clears
        13'b011_101_001_1000, // 6  R2
        13'b000_101_011_0011, // 7  R6
        13'b100_101_001_0011, // 8  R8 arm on done only
        13'b011_101_001_1000, // 9  R8 write clears and loads
        13'b000_101_011_0011, // 10 R6
        13'b011_101_001_1011, // 11 R2 write, no arm, flags kept
        13'b011_101_001_0111, // 12 R3
        13'b100_101_001_0111, // 13 R9 arm
        13'b011_101_001_0111, // 14 R9 second collision
        13'b101_101_001_0111, // 15 R9 read does not clear
        13'b100_101_001_0111, // 16 R7 re-arm
        13'b101_101_001_0000, // 17 R7 clear mid-transfer
        13'b000_101_010_0010, // 18 R11 irq masked, R3 transfer finished
        13'b100_101_001_0011, // 19 R7
        13'b101_101_001_0000, // 20 R7
        13'b011_001_001_1000, // 21 R4 ss_n high loads
        13'b011_000_001_0100, // 22 R4 ss_n low collides
        13'b000_000_011_0111, // 23 R6
        13'b100_001_001_0111, // 24 R4 arm
        13'b011_001_001_1000, // 25 R8 clear by write
        13'b011_010_001_1000, // 26 R5 before first edge
        13'b000_010_101_0000, // 27 R5 first sck edge
        13'b011_010_101_0100, // 28 R5 collision
        13'b000_010_011_0111, // 29 R5 done wins over edge
        13'b011_010_001_1111, // 30 R5 window closed
        13'b100_011_001_0111, // 31 R10 setup arm
        13'b101_011_001_0000, // 32 R10 setup clear
        13'b100_011_001_0000, // 33 R10 status read, no flags
        13'b000_011_011_0011, // 34 R6
        13'b101_011_001_0011  // 35 R10 no arm, no clear
    };

    function automatic string req_of(input int i);
        case (i)
            0:                          return "R1";
            1, 6, 11:                   return "R2";
            2, 12:                      return "R3";
            3, 7, 10, 23, 34:           return "R6";
            4, 5, 16, 17, 19, 20:       return "R7";
            8, 9, 25:                   return "R8";
            13, 14, 15:                 return "R9";
            18:                         return "R11";
            21, 22, 24:                 return "R4";
            26, 27, 28, 29, 30:         return "R5";
            default:                    return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic flags(input string req, input logic wc, input logic dn,
                         input logic iq);
        check(req, "wcol_flag", wcol_flag, wc);
        check(req, "done_flag", done_flag, dn);
        check(req, "spi_irq",   spi_irq,   iq);
    endtask

    task automatic idle_bus();
        bus_rd = 0; bus_wr = 0; bus_sel_data = 0; xfer_done = 0;
    endtask

    task automatic step_bus(input logic rd, input logic wr, input logic dat,
                            input logic xd);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_sel_data = dat; xfer_done = xd;
        @(posedge clk);
        #1;
        idle_bus();
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; idle_bus();
        is_master = 1; cpha = 0; ss_n = 1; sck = 0; irq_en = 1;
        repeat (3) @(posedge clk);
        #1;
        flags("R1", 1'b0, 1'b0, 1'b0);
        check("R1", "load_en", load_en, 1'b0);
        @(negedge clk);
        rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {bus_rd, bus_wr, bus_sel_data} = VEC[i][12:10];
            {is_master, cpha, ss_n}        = VEC[i][9:7];
            {sck, xfer_done, irq_en}       = VEC[i][6:4];
            #1;
            check(req_of(i), "load_en", load_en, VEC[i][3]);
            @(posedge clk);
            #1;
            flags(req_of(i), VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // Directed: reset drops a pending arm and both flags (R1)
        idle_bus(); irq_en = 1;
        step_bus(1'b1, 1'b0, 1'b0, 1'b0);   // status read arms on done_flag
        @(negedge clk); rst_n = 0;
        @(posedge clk); #1;
        flags("R1", 1'b0, 1'b0, 1'b0);
        @(negedge clk); rst_n = 1;
        step_bus(1'b0, 1'b0, 1'b0, 1'b1);   // completion
        flags("R6", 1'b0, 1'b1, 1'b1);
        step_bus(1'b1, 1'b0, 1'b1, 1'b0);   // data read without arm
        flags("R10", 1'b0, 1'b1, 1'b1);
        step_bus(1'b1, 1'b0, 1'b0, 1'b0);
        step_bus(1'b1, 1'b0, 1'b1, 1'b0);
        flags("R7", 1'b0, 1'b0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule